// File: doc/BRIEF.md
# Single-Word Accumulator Instruction Executor

A very small processor core that keeps program and data storage apart. It presents a 21-bit word address to a read-only program store and receives a 16-bit instruction word on a separate port in the same cycle. It holds one 8-bit working register, called W here. Every instruction fills exactly one word and completes in one clock.

The core recognises four kinds of instruction:
- loading an 8-bit literal into W;
- copying W to a data-side register;
- an explicit no-operation, which also covers any word the core does not recognise;
- a halt instruction that stops execution until the next reset.

Data-side accesses use a 12-bit address and an 8-bit write bus, with separate read and write strobes. The register target of a copy is either a location in a fixed access window or a location in the bank chosen by the `bankNum` input.

Fetch and execute do not overlap. The program store is read combinationally from `progAddr`. The decoded action takes effect at the next rising edge, and a data write is presented during the cycle in which its instruction word is on `progData`.

Top module: `lit_move_core`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the core clears the program counter (`progAddr`) to 0 and W (`wValue`) to 0, clears `sleeping`, and keeps `dataWr` low.
- R2: Every executed instruction advances `progAddr` by exactly one word at the following rising edge, and `progAddr` always shows the word currently being executed.
- R3: The program counter wraps from its all-ones value to 0.
- R4: Word `0x0E kk` loads W with `kk` at the next edge and performs no data write.
- R5: Word `0110 111a ffff ffff` drives `dataWr` high for that cycle with `dataWrData` equal to W. When a=0 and f < 0x80, `dataAddr` is `0x000 + f`.
- R6: When a=0 and f ≥ 0x80 in the copy instruction, `dataAddr` is `0xF00 + f`, the upper half of the access window.
- R7: When a=1 in the copy instruction, `dataAddr` is `{bankNum, f}`.
- R8: Word `0x0000` and every word that is not a load, copy or halt leave W unchanged, make no data write, and advance the program counter.
- R9: Word `0x0003` halts the core. The program counter stops at the word after the halt, `sleeping` goes high, and no further write or W change occurs, whatever `progData` holds.
- R10: A reset ends the halted state, and execution restarts from word 0.
- R11: `dataRd` is never asserted, because no instruction in this set reads data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| progAddr | output | 21 | Program word address (program counter) |
| progData | input | 16 | Instruction word read from `progAddr` |
| bankNum | input | 4 | Bank used by copy instructions with a=1 |
| dataAddr | output | 12 | Data-side register address |
| dataWrData | output | 8 | Data written on a copy |
| dataWr | output | 1 | Write strobe, high for one cycle per copy |
| dataRd | output | 1 | Read strobe |
| wValue | output | 8 | Current content of W |
| sleeping | output | 1 | High while halted |

## Verification
The bench targets address formation for the three cases of the copy instruction: low access half, high access half and banked. A design that ignored the bank bit, or forgot to lift upper-window addresses to 0xF00, would write to the wrong register, and the scoreboard would catch the mismatched address.

A run of unrecognised words follows a load. A core that decoded too loosely would then change W or issue stray writes.

After the halt word, the following words would load W and write if they ran. A core whose halt leaked would move its counter past the halt point or emit a write with nothing expected. A small-counter instance shows the counter folding back to 0. A second reset checks that the core leaves the halted state and restarts from word 0.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  // Strobes from control to datapath, one set per executed cycle
  typedef struct packed {
    logic advancePc;
    logic loadW;
    logic writeFile;
    logic enterSleep;
  } lmcStrobes_t;

  typedef enum logic {
    CORE_RUN  = 1'b0,
    CORE_HALT = 1'b1
  } coreState_t;

  localparam logic [7:0]  OP_LOADLIT_HI = 8'h0E;       // 0000 1110 kkkk kkkk
  localparam logic [6:0]  OP_COPYW_HI   = 7'b0110111;  // 0110 111a ffff ffff
  localparam logic [15:0] OP_HALT       = 16'h0003;

endpackage

// File: rtl/lmc_control.sv
module lmc_control
  import lmc_pkg::*;
#(
  parameter int InstrWidth = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [InstrWidth-1:0] instr,
  output lmcStrobes_t           strb,
  output logic                  halted
);

  coreState_t state;

  logic isLoadLit;
  logic isCopyW;
  logic isHalt;
  logic running;

  always_comb begin
    isLoadLit = (instr[15:8] == OP_LOADLIT_HI);
    isCopyW   = (instr[15:9] == OP_COPYW_HI);
    isHalt    = (instr == OP_HALT);
    running   = (state == CORE_RUN) && !rst;
  end

  always_comb begin
    strb.advancePc  = running;
    strb.loadW      = running && isLoadLit;
    strb.writeFile  = running && isCopyW;
    strb.enterSleep = running && isHalt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CORE_RUN;
    end else if (strb.enterSleep) begin
      state <= CORE_HALT;
    end
  end

  assign halted = (state == CORE_HALT);

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadW, strb.writeFile, strb.enterSleep}));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

endmodule

// File: rtl/lmc_datapath.sv
module lmc_datapath
  import lmc_pkg::*;
#(
  parameter int PcWidth       = 21,
  parameter int InstrWidth    = 16,
  parameter int DataWidth     = 8,
  parameter int DataAddrWidth = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  lmcStrobes_t              strb,
  input  logic [InstrWidth-1:0]    instr,
  input  logic [DataAddrWidth-DataWidth-1:0] bankNum,
  output logic [PcWidth-1:0]       pc,
  output logic [DataWidth-1:0]     wReg,
  output logic [DataAddrWidth-1:0] fileAddr,
  output logic [DataWidth-1:0]     fileData,
  output logic                     fileWr
);

  localparam int BankWidth = DataAddrWidth - DataWidth;

  logic [DataWidth-1:0] fieldF;
  logic                 bankedSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      wReg <= '0;
    end else begin
      if (strb.advancePc) pc <= pc + 1'b1;
      if (strb.loadW)     wReg <= instr[DataWidth-1:0];
    end
  end

  always_comb begin
    fieldF    = instr[DataWidth-1:0];
    bankedSel = instr[DataWidth];
    if (bankedSel) begin
      fileAddr = {bankNum, fieldF};
    end else if (fieldF[DataWidth-1]) begin
      // upper half of the access window sits in the top bank
      fileAddr = {{BankWidth{1'b1}}, fieldF};
    end else begin
      fileAddr = {{BankWidth{1'b0}}, fieldF};
    end
  end

  assign fileData = wReg;
  assign fileWr   = strb.writeFile;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.advancePc |=> pc == $past(pc) + 1'b1);

  // R8
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.loadW |=> $stable(wReg));

  // R4
  w_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadW |=> wReg == $past(instr[DataWidth-1:0]));

endmodule

// File: rtl/lit_move_core.sv
module lit_move_core
  import lmc_pkg::*;
#(
  parameter int PcWidth = 21
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PcWidth-1:0] progAddr,
  input  logic [15:0]        progData,
  input  logic [3:0]         bankNum,
  output logic [11:0]        dataAddr,
  output logic [7:0]         dataWrData,
  output logic               dataWr,
  output logic               dataRd,
  output logic [7:0]         wValue,
  output logic               sleeping
);

  lmcStrobes_t strb;

  lmc_control #(.InstrWidth(16)) ctrlInst (
    .clk    (clk),
    .rst    (rst),
    .instr  (progData),
    .strb   (strb),
    .halted (sleeping)
  );

  lmc_datapath #(
    .PcWidth(PcWidth), .InstrWidth(16), .DataWidth(8), .DataAddrWidth(12)
  ) dpInst (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .instr    (progData),
    .bankNum  (bankNum),
    .pc       (progAddr),
    .wReg     (wValue),
    .fileAddr (dataAddr),
    .fileData (dataWrData),
    .fileWr   (dataWr)
  );

  assign dataRd = 1'b0;

  // R9
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    sleeping |=> $stable(progAddr) && $stable(wValue));

  // R9
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    sleeping |-> !dataWr);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> progAddr == '0 && wValue == '0 && !sleeping);

endmodule

// File: tb/lit_move_core_test.sv
module lit_move_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] progAddr;
  logic [15:0] progData;
  logic [3:0]  bankNum = 4'h5;
  logic [11:0] dataAddr;
  logic [7:0]  dataWrData;
  logic        dataWr, dataRd, sleeping;
  logic [7:0]  wValue;

  logic [3:0]  wrapAddr;
  logic [11:0] wrapDataAddr;
  logic [7:0]  wrapWrData, wrapW;
  logic        wrapWr, wrapRd, wrapSleep;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct packed { logic [11:0] a; logic [7:0] d; } wrItem_t;
  wrItem_t expQ[$];

  logic [15:0] rom [16];

  always #10 clk = ~clk;  // 50 MHz

  assign progData = rom[progAddr[3:0]];

  lit_move_core uut (
    .clk(clk), .rst(rst), .progAddr(progAddr), .progData(progData),
    .bankNum(bankNum), .dataAddr(dataAddr), .dataWrData(dataWrData),
    .dataWr(dataWr), .dataRd(dataRd), .wValue(wValue), .sleeping(sleeping)
  );

  lit_move_core #(.PcWidth(4)) uutWrap (
    .clk(clk), .rst(rst), .progAddr(wrapAddr), .progData(16'h0000),
    .bankNum(4'h0), .dataAddr(wrapDataAddr), .dataWrData(wrapWrData),
    .dataWr(wrapWr), .dataRd(wrapRd), .wValue(wrapW), .sleeping(wrapSleep)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectWrite(input logic [11:0] a, input logic [7:0] d);
    expQ.push_back({a, d});
  endtask

  // monitor: compares each write against the queue, flags any read strobe
  always @(negedge clk) begin
    if (!rst && dataWr) begin
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected write", int'(dataAddr), 0);
      end else begin
        wrItem_t e;
        e = expQ.pop_front();
        check(dataAddr == e.a, "R5/R6/R7 write address", int'(dataAddr), int'(e.a));
        check(dataWrData == e.d, "R5 write data", int'(dataWrData), int'(e.d));
      end
    end
    if (dataRd) check(0, "R11 read strobe", 1, 0);
  end

  initial begin
    rom[0]  = 16'h0E55;  // load 55
    rom[1]  = 16'h6E82;  // copy a=0 f=82 -> F82
    rom[2]  = 16'h0E00;  // load 00
    rom[3]  = 16'h6E10;  // copy a=0 f=10 -> 010
    rom[4]  = 16'h0EA7;  // load A7
    rom[5]  = 16'h6F34;  // copy a=1 f=34 -> 534
    rom[6]  = 16'hFFFF;  // unrecognised
    rom[7]  = 16'h0000;  // nop
    rom[8]  = 16'h6E7F;  // copy a=0 f=7F -> 07F
    rom[9]  = 16'h0003;  // halt
    rom[10] = 16'h0E11;  // must not run
    rom[11] = 16'h6E20;  // must not run
    for (int i = 12; i < 16; i++) rom[i] = 16'h0E99;

    expectWrite(12'hF82, 8'h55);
    expectWrite(12'h010, 8'h00);
    expectWrite(12'h534, 8'hA7);
    expectWrite(12'h07F, 8'hA7);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(progAddr == 0, "R1 pc in reset", int'(progAddr), 0);
    check(wValue == 0, "R1 W in reset", int'(wValue), 0);
    check(!sleeping, "R1 sleeping in reset", int'(sleeping), 0);
    check(!dataWr, "R1 no write in reset", int'(dataWr), 0);
    rst = 1'b0;

    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      if (c == 1) begin
        check(progAddr == 1, "R2 pc step", int'(progAddr), 1);
        check(wValue == 8'h55, "R4 load literal", int'(wValue), 8'h55);
      end
      if (c == 3) check(wValue == 8'h00, "R4 load zero", int'(wValue), 0);
      if (c == 5) begin
        check(wValue == 8'hA7, "R4 load A7", int'(wValue), 8'hA7);
        check(progAddr == 5, "R2 pc", int'(progAddr), 5);
      end
      if (c == 8) begin
        check(wValue == 8'hA7, "R8 W unchanged by nop", int'(wValue), 8'hA7);
        check(progAddr == 8, "R8 pc advances", int'(progAddr), 8);
      end
      if (c == 10) begin
        check(progAddr == 10, "R9 pc after halt", int'(progAddr), 10);
        check(sleeping, "R9 sleeping", int'(sleeping), 1);
      end
      if (c == 15) check(wrapAddr == 15, "R3 before wrap", int'(wrapAddr), 15);
      if (c == 16) check(wrapAddr == 0, "R3 wrap to zero", int'(wrapAddr), 0);
      if (c == 30) begin
        check(progAddr == 10, "R9 pc frozen", int'(progAddr), 10);
        check(wValue == 8'hA7, "R9 W frozen", int'(wValue), 8'hA7);
        check(sleeping, "R9 still sleeping", int'(sleeping), 1);
      end
    end
    check(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);

    // R10: reset leaves halt and restarts at word 0
    rst = 1'b1;
    @(negedge clk);
    check(progAddr == 0, "R10 pc cleared", int'(progAddr), 0);
    check(!sleeping, "R10 halt left", int'(sleeping), 0);
    check(wValue == 0, "R1 W cleared", int'(wValue), 0);
    expectWrite(12'hF82, 8'h55);
    rst = 1'b0;
    @(negedge clk);
    check(progAddr == 1, "R10 restart pc", int'(progAddr), 1);
    check(wValue == 8'h55, "R10 restart W", int'(wValue), 8'h55);
    @(negedge clk);
    check(progAddr == 2, "R10 pc continues", int'(progAddr), 2);
    rst = 1'b1;
    @(negedge clk);
    check(expQ.size() == 0, "R10 write after restart", expQ.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule